// File: doc/BRIEF.md
# Low-Power to High-Speed Lane Transition Sequencer

This block sits between a byte packetizer and the line drivers of a serial display link with one clock lane and a configurable number of data lanes. A single level request from the packetizer (`hs_req`) asks for a high-speed burst. The block walks the clock lane out of the low-power stop state and into high-speed mode first. It then moves all data lanes through the same two-step low-power entry. Only after that does it open the gate that lets payload bytes onto the lanes.

When the request falls, the payload gate closes first. The data lanes stay in high-speed mode for a programmed drain time and then return to the stop state. The clock lane follows after a second programmed time, and the block is idle again. Each lane is driven by a 2-bit low-power line code, where bit 1 is the P wire and bit 0 is the N wire, and by a high-speed output enable. Serialization and the analog drivers are not part of this block.

Four parameters set the delays, each counted in byte clocks and each at least 1:
- `CLK_TO_DATA`: clock lane ahead of the data lanes.
- `DATA_LEAD`: data lane enable ahead of the payload.
- `DATA_DRAIN`: payload end ahead of the data lane exit.
- `CLK_TAIL`: data lane exit ahead of the clock lane exit.

One counter times the entry and a second counter times the exit.

Top module: `dphy_lp_hs_seq`

## Requirements
- R1: After reset and whenever idle, the clock lane and every data lane show line code 2'b11 (stop), all high-speed enables are low and `byte_valid` is low.
- R2: When a request is sampled high while idle, the clock lane shows 2'b01 for one cycle, then 2'b00 for one cycle, and then `clk_hs_oe` rises.
- R3: The data lanes show 2'b01 for one cycle, then 2'b00 for one cycle, and then their high-speed enables rise. This sequence starts only while the clock lane is already in high-speed mode.
- R4: `clk_hs_oe` is high for exactly `CLK_TO_DATA` cycles before the data lanes leave 2'b11.
- R5: `byte_valid` rises exactly `DATA_LEAD` cycles after the data lane enables rise, provided the request is still high.
- R6: `byte_valid` is high only while the clock and all data lane enables are high. It stays high while the request is high and falls in the cycle after the request is sampled low.
- R7: After `byte_valid` falls, the data lane enables stay high for exactly `DATA_DRAIN` cycles. The data lanes then return to 2'b11 with their enables low.
- R8: After the data lanes return to 2'b11, `clk_hs_oe` stays high for exactly `CLK_TAIL` cycles. The clock lane then returns to 2'b11 and the block is idle.
- R9: While a lane's high-speed enable is high, that lane's line code is 2'b00.
- R10: A request raised during the exit sequence has no effect on the exit timing. It starts nothing before idle is reached.
- R11: A request that falls before the payload gate opens still completes the whole entry sequence. The block then exits without ever raising `byte_valid`.
- R12: A request that is high when the exit completes starts a new entry after exactly one idle cycle.
- R13: All data lanes show the same line code and the same enable in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_req | input | 1 | High-speed burst request from the packetizer (level) |
| clk_lp | output | 2 | Clock lane line code {P,N} |
| clk_hs_oe | output | 1 | Clock lane high-speed output enable |
| data_lp | output | 2*N_LANES | Data lane line codes, lane i at bits [2i+1:2i] as {P,N} |
| data_hs_oe | output | N_LANES | Data lane high-speed output enables |
| byte_valid | output | 1 | Gate that releases payload bytes onto the data lanes |

## Verification
The bound checker watches several rules on every cycle:
- the ordering of the two entry steps on each lane;
- 2'b00 on any lane whose enable is high;
- the payload gate never open without all lanes in high-speed mode;
- the data lanes never leaving high-speed mode with the gate open;
- the clock lane leaving high-speed mode last and into the stop state;
- identical data lanes.

The exact delay lengths cannot be seen from those rules. Nor can the fate of requests that are withdrawn early, raised during exit, or held across an exit. Those are shown only by the bench's scenarios, which compare every output on every cycle against a queue-driven model.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CK_LP01,
    ST_CK_LP00,
    ST_CK_HS,
    ST_DT_LP01,
    ST_DT_LP00,
    ST_DT_LEAD,
    ST_DT_ACTIVE,
    ST_DT_DRAIN,
    ST_CK_TAIL
  } seq_state_e;

  // line codes, bit 1 = P wire, bit 0 = N wire
  localparam logic [1:0] LINE_STOP   = 2'b11;
  localparam logic [1:0] LINE_HS_RQ  = 2'b01;
  localparam logic [1:0] LINE_BRIDGE = 2'b00;

  typedef struct packed {
    logic [1:0] line;
    logic       hs_oe;
  } lane_ctrl_t;

endpackage

// File: rtl/dphy_seq_timer.sv
module dphy_seq_timer #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (clr)     count_nxt = '0;
    else if (en) count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

endmodule

// File: rtl/dphy_seq_fsm.sv
module dphy_seq_fsm
  import dphy_seq_pkg::*;
#(
  parameter int CLK_TO_DATA = 3,
  parameter int DATA_LEAD   = 2,
  parameter int DATA_DRAIN  = 2,
  parameter int CLK_TAIL    = 4,
  parameter int SW          = 3,
  parameter int EW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_req,
  input  logic [SW-1:0] start_cnt,
  input  logic [EW-1:0] end_cnt,
  output logic          start_clr,
  output logic          start_en,
  output logic          end_clr,
  output logic          end_en,
  output lane_ctrl_t    clk_ctrl,
  output lane_ctrl_t    data_ctrl,
  output logic          byte_valid
);

  localparam logic [SW-1:0] START_C2D_LAST  = SW'(CLK_TO_DATA - 1);
  localparam logic [SW-1:0] START_LEAD_LAST = SW'(CLK_TO_DATA + DATA_LEAD - 1);
  localparam logic [EW-1:0] END_DRAIN_LAST  = EW'(DATA_DRAIN - 1);
  localparam logic [EW-1:0] END_TAIL_LAST   = EW'(DATA_DRAIN + CLK_TAIL - 1);

  seq_state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:      if (hs_req) state_nxt = ST_CK_LP01;
      ST_CK_LP01:   state_nxt = ST_CK_LP00;
      ST_CK_LP00:   state_nxt = ST_CK_HS;
      ST_CK_HS:     if (start_cnt == START_C2D_LAST) state_nxt = ST_DT_LP01;
      ST_DT_LP01:   state_nxt = ST_DT_LP00;
      ST_DT_LP00:   state_nxt = ST_DT_LEAD;
      ST_DT_LEAD:   if (start_cnt == START_LEAD_LAST)
                      state_nxt = hs_req ? ST_DT_ACTIVE : ST_DT_DRAIN;
      ST_DT_ACTIVE: if (!hs_req) state_nxt = ST_DT_DRAIN;
      ST_DT_DRAIN:  if (end_cnt == END_DRAIN_LAST) state_nxt = ST_CK_TAIL;
      ST_CK_TAIL:   if (end_cnt == END_TAIL_LAST) state_nxt = ST_IDLE;
      default:      state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  // timer controls
  always_comb begin
    start_clr = (state == ST_IDLE);
    start_en  = (state == ST_CK_HS) || (state == ST_DT_LEAD);
    end_clr   = (state == ST_IDLE);
    end_en    = (state == ST_DT_DRAIN) || (state == ST_CK_TAIL);
  end

  // lane decode
  always_comb begin
    clk_ctrl   = '{line: LINE_STOP,   hs_oe: 1'b0};
    data_ctrl  = '{line: LINE_STOP,   hs_oe: 1'b0};
    byte_valid = 1'b0;
    unique case (state)
      ST_IDLE: ;
      ST_CK_LP01: clk_ctrl = '{line: LINE_HS_RQ,  hs_oe: 1'b0};
      ST_CK_LP00: clk_ctrl = '{line: LINE_BRIDGE, hs_oe: 1'b0};
      ST_CK_HS, ST_CK_TAIL:
        clk_ctrl = '{line: LINE_BRIDGE, hs_oe: 1'b1};
      ST_DT_LP01: begin
        clk_ctrl  = '{line: LINE_BRIDGE, hs_oe: 1'b1};
        data_ctrl = '{line: LINE_HS_RQ,  hs_oe: 1'b0};
      end
      ST_DT_LP00: begin
        clk_ctrl  = '{line: LINE_BRIDGE, hs_oe: 1'b1};
        data_ctrl = '{line: LINE_BRIDGE, hs_oe: 1'b0};
      end
      ST_DT_LEAD, ST_DT_DRAIN: begin
        clk_ctrl  = '{line: LINE_BRIDGE, hs_oe: 1'b1};
        data_ctrl = '{line: LINE_BRIDGE, hs_oe: 1'b1};
      end
      ST_DT_ACTIVE: begin
        clk_ctrl   = '{line: LINE_BRIDGE, hs_oe: 1'b1};
        data_ctrl  = '{line: LINE_BRIDGE, hs_oe: 1'b1};
        byte_valid = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dphy_lane_drive.sv
module dphy_lane_drive
  import dphy_seq_pkg::*;
(
  input  lane_ctrl_t ctrl,
  output logic [1:0] line,
  output logic       hs_oe
);

  always_comb begin
    line  = ctrl.line;
    hs_oe = ctrl.hs_oe;
  end

endmodule

// File: rtl/dphy_seq_rst_sync.sv
module dphy_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_n_sync = stage[1];

endmodule

// File: rtl/dphy_lp_hs_seq.sv
module dphy_lp_hs_seq
  import dphy_seq_pkg::*;
#(
  parameter int N_LANES     = 2,
  parameter int CLK_TO_DATA = 3,
  parameter int DATA_LEAD   = 2,
  parameter int DATA_DRAIN  = 2,
  parameter int CLK_TAIL    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hs_req,
  output logic [1:0]           clk_lp,
  output logic                 clk_hs_oe,
  output logic [2*N_LANES-1:0] data_lp,
  output logic [N_LANES-1:0]   data_hs_oe,
  output logic                 byte_valid
);

  localparam int SW = $clog2(CLK_TO_DATA + DATA_LEAD + 1);
  localparam int EW = $clog2(DATA_DRAIN + CLK_TAIL + 1);

  logic          rst_n_int;
  logic          start_clr, start_en, end_clr, end_en;
  logic [SW-1:0] start_cnt;
  logic [EW-1:0] end_cnt;
  lane_ctrl_t    clk_ctrl, data_ctrl;

  dphy_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dphy_seq_timer #(.WIDTH(SW)) u_start_tmr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (start_clr),
    .en    (start_en),
    .count (start_cnt)
  );

  dphy_seq_timer #(.WIDTH(EW)) u_end_tmr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (end_clr),
    .en    (end_en),
    .count (end_cnt)
  );

  dphy_seq_fsm #(
    .CLK_TO_DATA (CLK_TO_DATA),
    .DATA_LEAD   (DATA_LEAD),
    .DATA_DRAIN  (DATA_DRAIN),
    .CLK_TAIL    (CLK_TAIL),
    .SW          (SW),
    .EW          (EW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hs_req     (hs_req),
    .start_cnt  (start_cnt),
    .end_cnt    (end_cnt),
    .start_clr  (start_clr),
    .start_en   (start_en),
    .end_clr    (end_clr),
    .end_en     (end_en),
    .clk_ctrl   (clk_ctrl),
    .data_ctrl  (data_ctrl),
    .byte_valid (byte_valid)
  );

  dphy_lane_drive u_clk_lane (
    .ctrl  (clk_ctrl),
    .line  (clk_lp),
    .hs_oe (clk_hs_oe)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_data_lane
    dphy_lane_drive u_lane (
      .ctrl  (data_ctrl),
      .line  (data_lp[2*i +: 2]),
      .hs_oe (data_hs_oe[i])
    );
  end

endmodule

// File: rtl/dphy_seq_chk.sv
module dphy_seq_chk #(
  parameter int N_LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           clk_lp,
  input logic                 clk_hs_oe,
  input logic [2*N_LANES-1:0] data_lp,
  input logic [N_LANES-1:0]   data_hs_oe,
  input logic                 byte_valid
);

  // R1: clock lane stopped means the whole block is quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hs_oe && clk_lp == 2'b11) |-> (data_hs_oe == '0 && (&data_lp) && !byte_valid));

  // R2: clock lane request code only directly from stop
  a_r2_clk_rq_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lp == 2'b01) |-> ($past(clk_lp) == 2'b11));

  // R2: clock enable rises only after 01 then 00
  a_r2_clk_entry_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_hs_oe) |-> ($past(clk_lp) == 2'b00 && $past(clk_lp, 2) == 2'b01));

  // R3: data enable rises after 01 then 00, under a running clock lane
  a_r3_data_entry_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_hs_oe[0]) |-> ($past(data_lp[1:0]) == 2'b00 &&
                              $past(data_lp[1:0], 2) == 2'b01 &&
                              $past(clk_hs_oe, 2) && clk_hs_oe));

  // R6: payload gate needs every lane in high-speed mode
  a_r6_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (clk_hs_oe && (&data_hs_oe)));

  // R5: gate never opens in the same cycle the data lanes enter
  a_r5_valid_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> $past(&data_hs_oe));

  // R7: data lanes leave only with the gate already closed
  a_r7_drain_before_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_hs_oe[0]) |-> (!$past(byte_valid) && data_lp[1:0] == 2'b11));

  // R8: clock lane leaves last and lands in stop
  a_r8_clk_exits_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_hs_oe) |-> (data_hs_oe == '0 && $past(data_hs_oe) == '0 && clk_lp == 2'b11));

  // R9: lanes in high-speed mode hold 00
  a_r9_clk_hs_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hs_oe |-> (clk_lp == 2'b00));

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane_chk
    a_r9_data_hs_bridge: assert property (@(posedge clk) disable iff (!rst_n)
      data_hs_oe[i] |-> (data_lp[2*i +: 2] == 2'b00));
    // R13: every lane mirrors lane 0
    a_r13_lane_match: assert property (@(posedge clk) disable iff (!rst_n)
      (data_lp[2*i +: 2] == data_lp[1:0] && data_hs_oe[i] == data_hs_oe[0]));
  end

endmodule

bind dphy_lp_hs_seq dphy_seq_chk #(.N_LANES(N_LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_lp     (clk_lp),
  .clk_hs_oe  (clk_hs_oe),
  .data_lp    (data_lp),
  .data_hs_oe (data_hs_oe),
  .byte_valid (byte_valid)
);

// File: tb/dphy_lp_hs_seq_tb.sv
module dphy_lp_hs_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 2;
  localparam int C2D  = 3;
  localparam int LEAD = 2;
  localparam int DRN  = 2;
  localparam int TAIL = 4;

  // expected vector: {clk_lp[1:0], clk_hs_oe, lane_lp[1:0], lane_hs_oe, byte_valid}
  localparam logic [6:0] V_IDLE  = 7'b11_0_11_0_0;
  localparam logic [6:0] V_CK01  = 7'b01_0_11_0_0;
  localparam logic [6:0] V_CK00  = 7'b00_0_11_0_0;
  localparam logic [6:0] V_CKHS  = 7'b00_1_11_0_0;
  localparam logic [6:0] V_DT01  = 7'b00_1_01_0_0;
  localparam logic [6:0] V_DT00  = 7'b00_1_00_0_0;
  localparam logic [6:0] V_DTHS  = 7'b00_1_00_1_0;
  localparam logic [6:0] V_ACT   = 7'b00_1_00_1_1;

  logic                clk;
  logic                rst_n;
  logic                hs_req;
  logic [1:0]          clk_lp;
  logic                clk_hs_oe;
  logic [2*NL-1:0]     data_lp;
  logic [NL-1:0]       data_hs_oe;
  logic                byte_valid;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  string tag      = "R1";
  bit    done     = 0;

  dphy_lp_hs_seq #(
    .N_LANES     (NL),
    .CLK_TO_DATA (C2D),
    .DATA_LEAD   (LEAD),
    .DATA_DRAIN  (DRN),
    .CLK_TAIL    (TAIL)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_req     (hs_req),
    .clk_lp     (clk_lp),
    .clk_hs_oe  (clk_hs_oe),
    .data_lp    (data_lp),
    .data_hs_oe (data_hs_oe),
    .byte_valid (byte_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [6:0] exp_q[$];
  logic [6:0] cur = V_IDLE;
  int         mode = 0; // 0 idle, 1 entering, 2 active, 3 leaving

  function automatic void push_n(logic [6:0] v, int n);
    for (int k = 0; k < n; k++) exp_q.push_back(v);
  endfunction

  function automatic void load_exit();
    push_n(V_DTHS, DRN);
    push_n(V_CKHS, TAIL);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_q.delete();
      mode = 0;
      cur  = V_IDLE;
    end else begin
      case (mode)
        0: if (hs_req) begin
             push_n(V_CK01, 1);
             push_n(V_CK00, 1);
             push_n(V_CKHS, C2D);
             push_n(V_DT01, 1);
             push_n(V_DT00, 1);
             push_n(V_DTHS, LEAD);
             cur  = exp_q.pop_front();
             mode = 1;
           end else cur = V_IDLE;
        1: if (exp_q.size() > 0) cur = exp_q.pop_front();
           else if (hs_req) begin cur = V_ACT; mode = 2; end
           else begin load_exit(); cur = exp_q.pop_front(); mode = 3; end
        2: if (!hs_req) begin load_exit(); cur = exp_q.pop_front(); mode = 3; end
        default:
           if (exp_q.size() > 0) cur = exp_q.pop_front();
           else begin cur = V_IDLE; mode = 0; end
      endcase
    end
  end

  // ---------------- comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      logic [6:0] got;
      got = {clk_lp, clk_hs_oe, data_lp[1:0], data_hs_oe[0], byte_valid};
      n_checks++;
      if (got !== cur) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, cur);
      end
      n_checks++;
      if (data_lp !== {NL{data_lp[1:0]}} || data_hs_oe !== {NL{data_hs_oe[0]}}) begin
        n_fail++;
        $display("FAIL R13 cycle %0d: got lp %b oe %b expected all lanes equal to lane 0",
                 cyc, data_lp, data_hs_oe);
      end
    end
  end

  task automatic drive(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hs_req = v;
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    hs_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1 idle after reset";
    drive(1'b0, 6);

    tag = "R2 R3 R4 R5 R6 R7 R8 R9 normal burst";
    drive(1'b1, 20);
    drive(1'b0, 20);

    tag = "R11 request withdrawn during entry";
    drive(1'b1, 1);
    drive(1'b0, 25);

    tag = "R10 request raised during exit";
    drive(1'b1, 15);
    drive(1'b0, 2);
    drive(1'b1, 3);
    drive(1'b0, 20);

    tag = "R12 request held across exit";
    drive(1'b1, 16);
    drive(1'b0, 1);
    drive(1'b1, 25);
    drive(1'b0, 20);

    tag = "R6 long burst";
    drive(1'b1, 60);
    drive(1'b0, 20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got no completion expected finish before timeout");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule